// File: doc/BRIEF.md
# Hardware Monitor Interrupt Aggregator

This block collects out-of-limit flags from a hardware monitor's temperature and fan channels into sticky status registers. It drives one active-low interrupt pin with its own output enable, and two side-band event lines, one for power-management handling and one for system-management handling. The per-channel inputs are an ambient temperature error, one temperature error per remote diode, one fault flag per remote diode and one error per fan tachometer.

Enables are gated at three levels: a bit per channel, one bit per group (temperature, fan) and one global bit for the pin. The side-band lines use only the channel and group levels. Status bits are cleared by reading them. A bit whose stimulus is still present stays set. A diode fault has no status bit of its own: it stands in for a forced fault reading, and that reading sets the diode's temperature error bit.

Software reaches the registers through a simple port with single-cycle read and write strobes. Read data is registered. Measurement, limit comparison and the event controllers downstream are outside this block.

Top module: `hwIntAgg`

## Requirements
- R1: After reset, every status and enable register reads 0x00, `intPinN` is 1, `intPinOe` is 0, and `pmeEvt` and `smiEvt` are 0.
- R2: Status register 1 is at address 0x41: bit 0 is the ambient error, and bit 1+i is remote diode i. Status register 2 is at address 0x42: bit j is fan j. A stimulus that is high at a clock edge sets its bit, and the bit stays set after the stimulus drops until it is read.
- R3: A read strobe in cycle t puts the addressed register on `rdData` from cycle t+1 onward. `rdData` holds that value until the next read, and unmapped addresses read 0x00. For a status register, the bits reported are cleared at the edge that ends cycle t+1.
- R4: Setting has priority over clearing. A bit whose stimulus is high at the clearing edge stays set, and repeated reads return it for as long as the stimulus lasts.
- R5: The temperature enable register is at 0x78: bits 0..2 enable the status 1 bits one for one, and bit 7 is the temperature group enable. A set temperature bit pulls `intPinN` low only when its channel enable, the group enable and the global enable are all 1.
- R6: The fan group enable is bit 0 of the register at 0x80. The per-fan enables are bits 0..3 of the register at 0x81. A set fan bit pulls `intPinN` low only when its fan enable, the fan group enable and the global enable are all 1.
- R7: A high `diodeFault[i]` sets status 1 bit 1+i exactly as a remote error would. No other status bit changes.
- R8: `pmeEvt` and `smiEvt` are both 1 whenever any set status bit has its channel enable and its group enable at 1. The global enable and `monitorRun` have no effect on them.
- R9: `intPinN` can be 0 only while `monitorRun` is 1.
- R10: The special function register is at 0x7C: bit 0 selects the pin function, and bit 2 is the global enable. `intPinOe` is 1 only when both bits are 1. While `intPinOe` is 0, `intPinN` is 1.
- R11: If the global enable is cleared and then written to 1 again while an enabled status bit is still set, `intPinN` goes low in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| monitorRun | input | 1 | The monitor is in its operational state |
| ambErr | input | 1 | Ambient temperature out of limits |
| remErr | input | NUM_REMOTE | Remote diode temperature out of limits |
| diodeFault | input | NUM_REMOTE | Remote diode fault (the forced fault reading) |
| fanErr | input | NUM_FANS | Fan tachometer error |
| rdStb | input | 1 | Single-cycle read strobe |
| wrStb | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| intPinN | output | 1 | Interrupt pin value, active low |
| intPinOe | output | 1 | Interrupt pin output enable (0 means tristate) |
| pmeEvt | output | 1 | Power-management event |
| smiEvt | output | 1 | System-management event |

## Verification
The bench holds a stimulus active across several reads to confirm the bit survives. A design that lets the clear win would drop the bit and release the pin while the fault persists. It also pulses a stimulus on the clearing edge itself. A design that cleared everything, rather than only the reported bits, would lose that pulse. It toggles the global enable with status still set, and removes the channel, group and run qualifiers one at a time. A design with a gate missing, or with the global enable wired into the side-band lines, would then show a pin or event that differs from the reference model. Diode faults are pulsed alone, so a fault routed to the wrong bit, or given a status bit of its own, shows up on a read.

// File: rtl/hwIntPkg.sv
package hwIntPkg;
  localparam logic [7:0] ADDR_STS1   = 8'h41;
  localparam logic [7:0] ADDR_STS2   = 8'h42;
  localparam logic [7:0] ADDR_TEMPEN = 8'h78;
  localparam logic [7:0] ADDR_SFR    = 8'h7C;
  localparam logic [7:0] ADDR_FANGRP = 8'h80;
  localparam logic [7:0] ADDR_FANIND = 8'h81;

  localparam int SFR_SEL_BIT   = 0;
  localparam int SFR_GLOB_BIT  = 2;
  localparam int TEMP_GRP_BIT  = 7;
  localparam int FAN_GRP_BIT   = 0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STS1, SEL_STS2, SEL_TEMP, SEL_SFR, SEL_FGRP, SEL_FIND
  } rdSel_e;

  typedef struct packed {
    logic   wrTemp;
    logic   wrSfr;
    logic   wrFanGrp;
    logic   wrFanInd;
    logic   rdEn;
    rdSel_e rdSel;
    logic   clrS1;
    logic   clrS2;
  } ctrlStrobes_t;
endpackage

// File: rtl/hwIntCtrl.sv
module hwIntCtrl
  import hwIntPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdStb,
  input  logic         wrStb,
  input  logic [7:0]   addr,
  output ctrlStrobes_t st
);
  rdSel_e sel;
  logic   clrS1Q;
  logic   clrS2Q;

  always_comb begin
    case (addr)
      ADDR_STS1:   sel = SEL_STS1;
      ADDR_STS2:   sel = SEL_STS2;
      ADDR_TEMPEN: sel = SEL_TEMP;
      ADDR_SFR:    sel = SEL_SFR;
      ADDR_FANGRP: sel = SEL_FGRP;
      ADDR_FANIND: sel = SEL_FIND;
      default:     sel = SEL_NONE;
    endcase
  end

  // Clear strobes trail the read capture by one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrS1Q <= 1'b0;
      clrS2Q <= 1'b0;
    end else begin
      clrS1Q <= rdStb && (sel == SEL_STS1);
      clrS2Q <= rdStb && (sel == SEL_STS2);
    end
  end

  always_comb begin
    st.wrTemp   = wrStb && (sel == SEL_TEMP);
    st.wrSfr    = wrStb && (sel == SEL_SFR);
    st.wrFanGrp = wrStb && (sel == SEL_FGRP);
    st.wrFanInd = wrStb && (sel == SEL_FIND);
    st.rdEn     = rdStb;
    st.rdSel    = sel;
    st.clrS1    = clrS1Q;
    st.clrS2    = clrS2Q;
  end
endmodule

// File: rtl/hwIntData.sv
module hwIntData
  import hwIntPkg::*;
#(
  parameter int NUM_REMOTE = 2,
  parameter int NUM_FANS   = 4,
  localparam int S1W = 1 + NUM_REMOTE
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          st,
  input  logic                  monitorRun,
  input  logic                  ambErr,
  input  logic [NUM_REMOTE-1:0] remErr,
  input  logic [NUM_REMOTE-1:0] diodeFault,
  input  logic [NUM_FANS-1:0]   fanErr,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  output logic                  intPinN,
  output logic                  intPinOe,
  output logic                  evtOut
);
  logic [S1W-1:0]      status1;
  logic [NUM_FANS-1:0] status2;
  logic [S1W-1:0]      stim1;
  logic [7:0]          tempEn;
  logic [7:0]          sfr;
  logic [7:0]          fanGrp;
  logic [7:0]          fanInd;
  logic [7:0]          rdMux;
  logic [S1W-1:0]      clrMask1;
  logic [NUM_FANS-1:0] clrMask2;
  logic                tempHit;
  logic                fanHit;

  // A diode fault forces a fault reading, which trips that diode's limit
  assign stim1 = {remErr | diodeFault, ambErr};

  assign clrMask1 = st.clrS1 ? rdData[S1W-1:0]      : '0;
  assign clrMask2 = st.clrS2 ? rdData[NUM_FANS-1:0] : '0;

  always_comb begin
    rdMux = '0;
    case (st.rdSel)
      SEL_STS1: rdMux[S1W-1:0]      = status1;
      SEL_STS2: rdMux[NUM_FANS-1:0] = status2;
      SEL_TEMP: rdMux = tempEn;
      SEL_SFR:  rdMux = sfr;
      SEL_FGRP: rdMux = fanGrp;
      SEL_FIND: rdMux = fanInd;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status1 <= '0;
      status2 <= '0;
      tempEn  <= '0;
      sfr     <= '0;
      fanGrp  <= '0;
      fanInd  <= '0;
      rdData  <= '0;
    end else begin
      status1 <= (status1 & ~clrMask1) | stim1;
      status2 <= (status2 & ~clrMask2) | fanErr;
      if (st.wrTemp)   tempEn <= wrData;
      if (st.wrSfr)    sfr    <= wrData;
      if (st.wrFanGrp) fanGrp <= wrData;
      if (st.wrFanInd) fanInd <= wrData;
      if (st.rdEn)     rdData <= rdMux;
    end
  end

  assign tempHit  = (|(status1 & tempEn[S1W-1:0])) && tempEn[TEMP_GRP_BIT];
  assign fanHit   = (|(status2 & fanInd[NUM_FANS-1:0])) && fanGrp[FAN_GRP_BIT];
  assign evtOut   = tempHit || fanHit;
  assign intPinOe = sfr[SFR_SEL_BIT] && sfr[SFR_GLOB_BIT];
  assign intPinN  = !(intPinOe && monitorRun && evtOut);
endmodule

// File: rtl/hwIntAgg.sv
module hwIntAgg
  import hwIntPkg::*;
#(
  parameter int NUM_REMOTE = 2,
  parameter int NUM_FANS   = 4
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  monitorRun,
  input  logic                  ambErr,
  input  logic [NUM_REMOTE-1:0] remErr,
  input  logic [NUM_REMOTE-1:0] diodeFault,
  input  logic [NUM_FANS-1:0]   fanErr,
  input  logic                  rdStb,
  input  logic                  wrStb,
  input  logic [7:0]            addr,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  output logic                  intPinN,
  output logic                  intPinOe,
  output logic                  pmeEvt,
  output logic                  smiEvt
);
  ctrlStrobes_t st;
  logic         evt;

  hwIntCtrl uCtrl (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .addr(addr), .st(st)
  );

  hwIntData #(.NUM_REMOTE(NUM_REMOTE), .NUM_FANS(NUM_FANS)) uData (
    .clk(clk), .rstN(rstN), .st(st), .monitorRun(monitorRun),
    .ambErr(ambErr), .remErr(remErr), .diodeFault(diodeFault), .fanErr(fanErr),
    .wrData(wrData), .rdData(rdData), .intPinN(intPinN), .intPinOe(intPinOe),
    .evtOut(evt)
  );

  assign pmeEvt = evt;
  assign smiEvt = evt;
endmodule

// File: rtl/hwIntChk.sv
module hwIntChk #(
  parameter int S1W = 3
)(
  input logic           clk,
  input logic           rstN,
  input logic           monitorRun,
  input logic           intPinN,
  input logic           intPinOe,
  input logic           pmeEvt,
  input logic           smiEvt,
  input logic [S1W-1:0] status1,
  input logic [S1W-1:0] stim1,
  input logic           clrS1
);
  AST_PIN_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !monitorRun |-> intPinN); // R9

  AST_PIN_HIGH_UNDRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !intPinOe |-> intPinN); // R10

  AST_PIN_IMPLIES_EVT: assert property (@(posedge clk) disable iff (!rstN)
    !intPinN |-> (pmeEvt && smiEvt)); // R8

  AST_EVT_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    pmeEvt == smiEvt); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|stim1) |=> ((status1 & $past(stim1)) == $past(stim1))); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(status1) & ~status1)) |-> $past(clrS1)); // R2
endmodule

bind hwIntAgg hwIntChk #(.S1W(1 + NUM_REMOTE)) uChk (
  .clk(clk), .rstN(rstN), .monitorRun(monitorRun), .intPinN(intPinN),
  .intPinOe(intPinOe), .pmeEvt(pmeEvt), .smiEvt(smiEvt),
  .status1(uData.status1), .stim1(uData.stim1), .clrS1(st.clrS1)
);

// File: tb/tb_hwIntAgg.sv
`timescale 1ns/1ps
module tb_hwIntAgg;
  localparam logic [7:0] A_S1 = 8'h41, A_S2 = 8'h42, A_TEMP = 8'h78,
                         A_SFR = 8'h7C, A_FGRP = 8'h80, A_FIND = 8'h81;

  logic clk = 0, rstN = 0, monitorRun = 1, ambErr = 0;
  logic [1:0] remErr = 0, diodeFault = 0;
  logic [3:0] fanErr = 0;
  logic rdStb = 0, wrStb = 0;
  logic [7:0] addr = 0, wrData = 0, rdData;
  logic intPinN, intPinOe, pmeEvt, smiEvt;

  int checks = 0, failures = 0;

  hwIntAgg dut (.*);

  always #2 clk = ~clk;

  // Behavioural reference
  logic [2:0] mS1; logic [3:0] mS2;
  logic [7:0] mTemp, mSfr, mFGrp, mFInd, mRd;
  logic mClr1, mClr2;

  function automatic logic [7:0] regVal(input logic [7:0] a);
    case (a)
      A_S1:   return {5'd0, mS1};
      A_S2:   return {4'd0, mS2};
      A_TEMP: return mTemp;
      A_SFR:  return mSfr;
      A_FGRP: return mFGrp;
      A_FIND: return mFInd;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mTemp = 0; mSfr = 0; mFGrp = 0; mFInd = 0;
      mRd = 0; mClr1 = 0; mClr2 = 0;
    end else begin
      logic [2:0] n1; logic [3:0] n2; logic [7:0] nRd;
      n1 = mS1; n2 = mS2;
      if (mClr1) n1 = n1 & ~mRd[2:0];
      if (mClr2) n2 = n2 & ~mRd[3:0];
      n1 = n1 | {remErr | diodeFault, ambErr};
      n2 = n2 | fanErr;
      nRd = rdStb ? regVal(addr) : mRd;
      mClr1 = rdStb && addr == A_S1;
      mClr2 = rdStb && addr == A_S2;
      if (wrStb) begin
        if (addr == A_TEMP) mTemp = wrData;
        if (addr == A_SFR)  mSfr  = wrData;
        if (addr == A_FGRP) mFGrp = wrData;
        if (addr == A_FIND) mFInd = wrData;
      end
      mS1 = n1; mS2 = n2; mRd = nRd;
    end
  end

  function automatic logic expEvt();
    return ((|(mS1 & mTemp[2:0])) && mTemp[7]) || ((|(mS2 & mFInd[3:0])) && mFGrp[0]);
  endfunction
  function automatic logic expOe();
    return mSfr[0] && mSfr[2];
  endfunction
  function automatic logic expPinN();
    return !(expOe() && monitorRun && expEvt());
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, mid-cycle
  always @(negedge clk) if (rstN) begin
    chk(intPinN == expPinN(), "R5/R6/R9 intPinN vs model", intPinN, expPinN());
    chk(intPinOe == expOe(), "R10 intPinOe vs model", intPinOe, expOe());
    chk(pmeEvt == expEvt() && smiEvt == expEvt(), "R8 events vs model",
        {pmeEvt, smiEvt}, {expEvt(), expEvt()});
    chk(rdData == mRd, "R3 rdData vs model", rdData, mRd);
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) tick(); endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wrStb = 1; addr = a; wrData = d; tick(); wrStb = 0;
  endtask
  task automatic rd(input logic [7:0] a);
    rdStb = 1; addr = a; tick(); rdStb = 0;
  endtask
  task automatic mid(); @(negedge clk); #0.1; endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #9 rstN = 1;
    tick();
    mid();
    chk(intPinN == 1 && intPinOe == 0 && pmeEvt == 0 && smiEvt == 0 && rdData == 0,
        "R1 reset outputs", {intPinN, intPinOe, pmeEvt, smiEvt}, 4'b1000);
    rd(A_SFR); mid(); chk(rdData == 0, "R1 sfr reset", rdData, 0);

    // R2 sticky after a one-cycle pulse
    ambErr = 1; tick(); ambErr = 0; idle(2);
    rd(A_S1); mid(); chk(rdData == 8'h01, "R2 sticky ambient", rdData, 1);
    idle(1);
    rd(A_S1); mid(); chk(rdData == 8'h00, "R3 cleared after read", rdData, 0);
    rd(8'h10); mid(); chk(rdData == 8'h00, "R3 unmapped reads zero", rdData, 0);

    // R4 persistent stimulus survives reads
    ambErr = 1; tick();
    rd(A_S1); idle(1); rd(A_S1); mid();
    chk(rdData == 8'h01, "R4 held bit survives clear", rdData, 1);
    rd(A_S1); ambErr = 0; idle(2);
    rd(A_S1); mid(); chk(rdData == 8'h00, "R4 clears once released", rdData, 0);

    // R5 three-level gating for temperature
    ambErr = 1; tick(); ambErr = 0;
    wr(A_TEMP, 8'h01); mid(); chk(pmeEvt == 0, "R5 no group enable", pmeEvt, 0);
    wr(A_TEMP, 8'h81); mid();
    chk(pmeEvt == 1 && smiEvt == 1 && intPinN == 1, "R8 events without global",
        {pmeEvt, smiEvt, intPinN}, 3'b111);
    wr(A_SFR, 8'h04); mid(); chk(intPinOe == 0 && intPinN == 1, "R10 not selected", intPinOe, 0);
    wr(A_SFR, 8'h05); mid(); chk(intPinOe == 1 && intPinN == 0, "R5 pin asserted", intPinN, 0);
    monitorRun = 0; mid(); chk(intPinN == 1 && pmeEvt == 1, "R9 not operational", intPinN, 1);
    monitorRun = 1;
    wr(A_TEMP, 8'h80); mid(); chk(intPinN == 1, "R5 channel disabled", intPinN, 1);
    wr(A_TEMP, 8'h87);

    // R11 re-arm global enable with status still set
    wr(A_SFR, 8'h01); mid(); chk(intPinN == 1, "R11 global off", intPinN, 1);
    wr(A_SFR, 8'h05); mid(); chk(intPinN == 0, "R11 reasserts next cycle", intPinN, 0);
    rd(A_S1); idle(1); mid(); chk(intPinN == 1, "R3 read releases pin", intPinN, 1);

    // Pulse lands on the clearing edge: not lost
    rd(A_S1); ambErr = 1; tick(); ambErr = 0; idle(1);
    rd(A_S1); mid(); chk(rdData == 8'h01, "R4 pulse on clearing edge kept", rdData, 1);

    // R7 diode fault sets the remote bit only
    idle(1); diodeFault = 2'b10; tick(); diodeFault = 0; idle(1);
    mid(); chk(intPinN == 0, "R7 fault drives pin", intPinN, 0);
    rd(A_S1); mid(); chk(rdData == 8'h04, "R7 fault sets remote bit", rdData, 4);
    idle(1); remErr = 2'b01; tick(); remErr = 0; idle(1);
    rd(A_S1); mid(); chk(rdData == 8'h02, "R2 remote 0 bit", rdData, 2);

    // R6 fan gating
    idle(1); fanErr = 4'b0100; tick(); fanErr = 0;
    wr(A_FIND, 8'h04); mid(); chk(intPinN == 1, "R6 fan group off", intPinN, 1);
    wr(A_FGRP, 8'h01); mid(); chk(intPinN == 0 && pmeEvt == 1, "R6 fan asserts", intPinN, 0);
    rd(A_S2); mid(); chk(rdData == 8'h04, "R2 fan status", rdData, 4);
    idle(1); mid(); chk(intPinN == 1, "R6 fan released", intPinN, 1);
    fanErr = 4'b1001; idle(3); rd(A_FIND); mid();
    chk(rdData == 8'h04, "R3 enable readback", rdData, 4);
    fanErr = 0; idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule